// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Register

This block keeps the event status word of an SD/MMC host controller and drives its interrupt line. The command, data, buffer and card-detect logic around it hand in single-cycle event pulses. Each pulse sets a sticky bit, and that bit stays set until software writes a one to its position. Level indications, such as buffer fill state and the running card clock, are shown in the same word. They are re-sampled every cycle and are never latched. When a write-CRC failure is flagged, a 2-bit card status code is stored alongside it in the word.

A separate interrupt-enable word chooses which events drive the interrupt output. Its bit positions do not match the status positions, so the block maps each enable to its source. The interrupt and wake outputs are registered. An error summary output is high while any error bit is set. Software can clear every event it has seen by writing back the value it read. Writing zero to the enable word masks every interrupt source.

All pins are plain control and status signals that are sampled or updated on each clock. No transfer at this block's edge waits on back-pressure, so no valid/ready handshake is used.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, `stat_q`, `ien_q`, `irq`, `wake` and `err_any` are all zero.
- R2: A pulse on `evt_pulse` at a sticky position sets that status bit at the same clock edge, and the bit stays set until it is cleared. The sticky positions are 31 (card inserted), 30 (card removed), 25 (buffer underrun), 24 (buffer overflow), 14 (SDIO interrupt), 13 (command response ended), 12 (write finished), 11 (read or transfer finished), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout). Pulses at other positions are ignored.
- R3: When `stat_wr` is high, each sticky bit whose `stat_wdata` bit is one is cleared at that edge. Sticky bits whose `stat_wdata` bit is zero keep their value.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the bit is set after that edge.
- R5: Status bits 29, 28, 27, 26, 8, 7 and 6 show the value of `lvl_in` at the same position, delayed by one clock. Writes to `stat_q` have no effect on them.
- R6: A pulse on `evt_pulse[2]` copies `wcrc_code` into status bits 10:9. A value of 2 in this field means the card returned no CRC status. The field goes to zero when bit 2 is cleared and no pulse arrives in that cycle. Writes to bits 10:9 themselves are ignored.
- R7: `err_any` is high exactly when one of the status bits 5, 3, 2, 1 or 0 is set.
- R8: `ien_wr` loads `ien_q` with the writable enable bits, which are 4:0 and 18:12. All other enable bits read zero. An all-zero enable word keeps `irq` and `wake` low.
- R9: One cycle after a status change, `irq` is the OR of enabled sources. The enable-to-source mapping is: enable 0 to status 11, 1 to 12, 2 to 13, 3 to 6, 4 to 7, 12 to the `dat0_in` level, 13 to 14, 14 to 30, and 15 to 31.
- R10: `wake` is registered in the same way from the wake enables. Enable 16 maps to status 14, 17 to status 31, and 18 to status 30.
- R11: Status bits 23 to 15 and bit 4 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 32 | Single-cycle event pulses, one per status position |
| lvl_in | input | 32 | Live level indications at status positions |
| wcrc_code | input | 2 | Card CRC status code that goes with a write CRC error |
| dat0_in | input | 1 | DAT0 line level used as an interrupt source |
| stat_wr | input | 1 | Write strobe for the status word (write-one-to-clear) |
| stat_wdata | input | 32 | Status write data |
| ien_wr | input | 1 | Write strobe for the enable word |
| ien_wdata | input | 32 | Enable write data |
| stat_q | output | 32 | Status word |
| ien_q | output | 32 | Enable word |
| err_any | output | 1 | Error summary |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake request |

## Verification
Directed patterns come first.
- One event followed by idle cycles shows whether bits are sticky.
- A partial clear shows whether the write is treated as write-one-to-clear or as a plain write.
- An event and a clear at the same bit in the same cycle show which one has priority.
- An all-ones write on top of live levels shows whether the level bits and the 10:9 code field are protected from writes.
- Enabling one source at a time shows whether each enable is mapped to the correct source, as opposed to one at the same bit position.

After that, sparse random events, random clears and occasional enable rewrites are run against a bench model. This mixes the three kinds of status bit in ways the directed cases do not reach.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int STAT_W = 32;
  localparam int CODE_W = 2;
  localparam int CODE_LSB = 9;
  localparam int WCRC_BIT = 2;
  localparam int NSRC = 19;
  localparam int NRUN = 16;

  localparam logic [STAT_W-1:0] STICKY_MASK = 32'hC300_782F;
  localparam logic [STAT_W-1:0] LEVEL_MASK  = 32'h3C00_01C0;
  localparam logic [STAT_W-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [STAT_W-1:0] IEN_MASK    = 32'h0007_F01F;
  localparam logic [STAT_W-1:0] CODE_MASK   = {{(STAT_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << CODE_LSB;

  // enable index -> source
  typedef enum int {
    SRC_RD_DONE = 0, SRC_WR_DONE = 1, SRC_CMD_END = 2, SRC_BUF_WR = 3,
    SRC_BUF_RD = 4, SRC_DAT0 = 12, SRC_SDIO = 13, SRC_REMOVE = 14,
    SRC_INSERT = 15, WK_SDIO = 16, WK_INSERT = 17, WK_REMOVE = 18
  } src_idx_e;

  function automatic logic [NSRC-1:0] src_vec(input logic [STAT_W-1:0] st, input logic dat0);
    logic [NSRC-1:0] s;
    s = '0;
    s[SRC_RD_DONE] = st[11];
    s[SRC_WR_DONE] = st[12];
    s[SRC_CMD_END] = st[13];
    s[SRC_BUF_WR]  = st[6];
    s[SRC_BUF_RD]  = st[7];
    s[SRC_DAT0]    = dat0;
    s[SRC_SDIO]    = st[14];
    s[SRC_REMOVE]  = st[30];
    s[SRC_INSERT]  = st[31];
    s[WK_SDIO]     = st[14];
    s[WK_INSERT]   = st[31];
    s[WK_REMOVE]   = st[30];
    return s;
  endfunction
endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_ff
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign bits_o[i] = q;
    end else begin : g_zero
      assign bits_o[i] = 1'b0;
    end
  end

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i & KEEP)) |=>
      ((bits_o & $past(set_i & clr_i & KEEP)) == $past(set_i & clr_i & KEEP)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & KEEP)) |=> ((bits_o & $past(clr_i & ~set_i & KEEP)) == '0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bits_o) |=> ((bits_o & $past(bits_o & ~clr_i)) == $past(bits_o & ~clr_i)));
endmodule

// File: rtl/sdh_crc_code.sv
module sdh_crc_code #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt_i,
  input  logic          clr_i,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_o <= '0;
    else if (err_evt_i) code_o <= code_i;
    else if (clr_i)     code_o <= '0;
  end

  // R6
  code_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> (code_o == $past(code_i)));

  // R6
  code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !err_evt_i) |=> (code_o == '0));
endmodule

// File: rtl/sdh_irq_gen.sv
module sdh_irq_gen
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] ien_i,
  input  logic              dat0_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int NWAKE = NSRC - NRUN;

  logic [NSRC-1:0]  src;
  logic [NRUN-1:0]  run_hit;
  logic [NWAKE-1:0] wake_hit;

  always_comb begin
    src      = src_vec(stat_i, dat0_i);
    run_hit  = src[NRUN-1:0] & ien_i[NRUN-1:0];
    wake_hit = src[NSRC-1:NRUN] & ien_i[NSRC-1:NRUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |run_hit;
      wake_o <= |wake_hit;
    end
  end

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i == '0) |=> (!irq_o && !wake_o));
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_pulse,
  input  logic [STAT_W-1:0] lvl_in,
  input  logic [CODE_W-1:0] wcrc_code,
  input  logic              dat0_in,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              ien_wr,
  input  logic [STAT_W-1:0] ien_wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] ien_q,
  output logic              err_any,
  output logic              irq,
  output logic              wake
);
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] sticky_q;
  logic [STAT_W-1:0] level_q;
  logic [CODE_W-1:0] code_q;

  assign clr_vec = stat_wr ? stat_wdata : '0;

  sdh_sticky_bank #(.W(STAT_W), .KEEP(STICKY_MASK)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(clr_vec), .bits_o(sticky_q)
  );

  sdh_crc_code #(.CW(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n),
    .err_evt_i(evt_pulse[WCRC_BIT]), .clr_i(clr_vec[WCRC_BIT]),
    .code_i(wcrc_code), .code_o(code_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= lvl_in & LEVEL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= ien_wdata & IEN_MASK;
  end

  assign stat_q  = sticky_q | level_q | (STAT_W'(code_q) << CODE_LSB);
  assign err_any = |(stat_q & ERR_MASK);

  sdh_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_q), .ien_i(ien_q),
    .dat0_i(dat0_in), .irq_o(irq), .wake_o(wake)
  );

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~(STICKY_MASK | LEVEL_MASK | CODE_MASK)) == '0);

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & LEVEL_MASK) == ($past(lvl_in) & LEVEL_MASK)));
endmodule

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
  localparam logic [31:0] M_STICKY = 32'hC300_782F;
  localparam logic [31:0] M_LEVEL  = 32'h3C00_01C0;
  localparam logic [31:0] M_IEN    = 32'h0007_F01F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] evt_pulse = '0, lvl_in = '0, stat_wdata = '0, ien_wdata = '0;
  logic [1:0]  wcrc_code = '0;
  logic dat0_in = 1'b0, stat_wr = 1'b0, ien_wr = 1'b0;
  logic [31:0] stat_q, ien_q;
  logic err_any, irq, wake;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sticky = '0, m_lvl = '0, m_ien = '0;
  logic [1:0]  m_code = '0;
  logic        m_irq = 1'b0, m_wake = 1'b0;

  always #2 clk = ~clk;

  sdh_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .lvl_in(lvl_in),
    .wcrc_code(wcrc_code), .dat0_in(dat0_in), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .stat_q(stat_q), .ien_q(ien_q), .err_any(err_any), .irq(irq), .wake(wake)
  );

  function automatic logic [31:0] m_stat();
    return m_sticky | m_lvl | (32'(m_code) << 9);
  endfunction

  // enable i -> source per R9/R10
  function automatic logic [18:0] m_src(input logic [31:0] st, input logic d0);
    logic [18:0] s = '0;
    s[0] = st[11]; s[1] = st[12]; s[2] = st[13]; s[3] = st[6]; s[4] = st[7];
    s[12] = d0; s[13] = st[14]; s[14] = st[30]; s[15] = st[31];
    s[16] = st[14]; s[17] = st[31]; s[18] = st[30];
    return s;
  endfunction

  task automatic chk32(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk32(tag, "stat_q", stat_q, m_stat());
    chk32(tag, "ien_q", ien_q, m_ien);
    chk32(tag, "irq", 32'(irq), 32'(m_irq));
    chk32(tag, "wake", 32'(wake), 32'(m_wake));
    chk32(tag, "err_any", 32'(err_any), 32'(|(m_stat() & 32'h2F)));
  endtask

  task automatic cyc(input string tag, input logic [31:0] ev, input logic [31:0] lv,
                     input logic [1:0] cd, input logic d0, input logic sw,
                     input logic [31:0] sd, input logic iw, input logic [31:0] id);
    logic [18:0] s;
    evt_pulse = ev; lvl_in = lv; wcrc_code = cd; dat0_in = d0;
    stat_wr = sw; stat_wdata = sd; ien_wr = iw; ien_wdata = id;
    @(posedge clk);
    s = m_src(m_stat(), d0);
    m_irq  = |(s[15:0] & m_ien[15:0]);
    m_wake = |(s[18:16] & m_ien[18:16]);
    if (ev[2]) m_code = cd;
    else if (sw && sd[2]) m_code = '0;
    m_sticky = (m_sticky & ~(sw ? sd : 32'h0)) | (ev & M_STICKY);
    m_lvl = lv & M_LEVEL;
    if (iw) m_ien = id & M_IEN;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, '0, '0, '0, 1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2: sticky capture and hold, non-sticky pulse ignored
    cyc("R2", (32'h1 << 13) | (32'h1 << 4) | (32'h1 << 20), '0, '0, 0, 0, '0, 0, '0);
    idle("R2"); idle("R2");

    // R3: partial write-one-to-clear
    cyc("R3", 32'h8000_0003, '0, '0, 0, 0, '0, 0, '0);
    cyc("R3", '0, '0, '0, 0, 1, 32'h8000_0001, 0, '0);
    cyc("R3", '0, '0, '0, 0, 1, 32'h0, 0, '0);

    // R4: event beats same-cycle clear
    cyc("R4", 32'h1 << 12, '0, '0, 0, 1, 32'h1 << 12, 0, '0);
    idle("R4");
    cyc("R4", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);

    // R5: level bits follow inputs, writes ignored
    cyc("R5", '0, 32'hFFFF_FFFF, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);
    cyc("R5", '0, 32'h1400_0080, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);
    idle("R5");

    // R6: code field capture, write to 10:9 ignored, clear with bit 2
    cyc("R6", 32'h4, '0, 2'd2, 0, 0, '0, 0, '0);
    cyc("R6", '0, '0, 2'd3, 0, 1, 32'h600, 0, '0);
    cyc("R6", '0, '0, 2'd3, 0, 1, 32'h4, 0, '0);
    cyc("R6", 32'h4, '0, 2'd1, 0, 1, 32'h4, 0, '0);
    cyc("R6", 32'h4, '0, 2'd3, 0, 0, '0, 0, '0);
    cyc("R6", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);

    // R7: each error bit raises the summary
    for (int b = 0; b < 6; b++) begin
      cyc("R7", 32'h1 << b, '0, '0, 0, 0, '0, 0, '0);
      cyc("R7", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);
    end

    // R8: writable enable bits, zero masks everything
    cyc("R8", 32'hC000_7800, 32'hFFFF_FFFF, '0, 1, 0, '0, 1, 32'hFFFF_FFFF);
    idle("R8");
    cyc("R8", 32'hC000_7800, 32'hFFFF_FFFF, '0, 1, 0, '0, 1, 32'h0);
    cyc("R8", '0, 32'hFFFF_FFFF, '0, 1, 0, '0, 0, '0);
    cyc("R8", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);

    // R9 and R10: one enable at a time, stimulating only its own source first
    for (int e = 0; e < 19; e++) begin
      if (M_IEN[e]) begin
        cyc("R9", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 1, 32'h1 << e);
        cyc("R9", 32'h0000_0FFF, 32'h0000_0E3F, '0, 0, 0, '0, 0, '0);
        cyc("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, 1, 0, '0, 0, '0);
        cyc(e >= 16 ? "R10" : "R9", '0, 32'hFFFF_FFFF, '0, 1, 0, '0, 0, '0);
      end
    end
    cyc("R10", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 1, 32'h0007_0000);
    cyc("R10", 32'h4000_0000, '0, '0, 0, 0, '0, 0, '0);
    idle("R10");

    // R11: everything high, unused bits stay zero
    cyc("R11", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1, 0, '0, 0, '0);
    idle("R11");
    cyc("R11", '0, '0, '0, 0, 1, 32'hFFFF_FFFF, 0, '0);

    // random mix (R2 R3 R4 R6 R9 as the main function)
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ev, lv, sd, id;
      logic sw, iw;
      ev = $urandom & $urandom & $urandom;
      lv = $urandom;
      sd = $urandom;
      id = $urandom;
      sw = ($urandom % 4) == 0;
      iw = ($urandom % 16) == 0;
      cyc("R9", ev, lv, 2'($urandom), 1'($urandom), sw, sd, iw, id);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule